// File: doc/BRIEF.md
# Bit-Position Immediate Unit

This block carries out the bit-immediate group of an 8-bit accumulator machine. It takes the accumulator, a 3-bit operation select and a 3-bit operand, and it returns the value to be written back into the accumulator. The accumulator is both the source and the destination.

The same 3-bit operand has two meanings. For the four movement operations (rotate left, shift left, logical shift right, arithmetic shift right) it is a shift or rotate amount. For the four single-bit operations (clear, set, toggle, extract) it is a bit index. The surrounding decoder selects this unit when the first instruction byte is 1111_0011 and the top two bits of the second byte are 10. It passes the middle three bits of that byte as the operation and the low three bits as the operand.

The unit is purely combinational and has no states. The result follows the inputs in the same cycle. Movement operations go through a logarithmic barrel stage chain, and single-bit operations go through a one-hot position decoder. A final selector driven by the top bit of the operation code picks between the two.

Top module: `bitpos_imm_unit`

## Requirements
- R1: Operation 0 rotates the accumulator left by n places, with bit 7 entering bit 0 on each step. The number of set bits is preserved.
- R2: Operation 1 shifts left by n places and fills the low n bits with zeros.
- R3: Operation 2 shifts right by n places and fills the high n bits with zeros.
- R4: Operation 3 shifts right by n places and fills the high bits with copies of bit 7.
- R5: Operation 4 forces bit n to 0 and leaves all other bits unchanged.
- R6: Operation 5 forces bit n to 1 and leaves all other bits unchanged.
- R7: Operation 6 inverts bit n and leaves all other bits unchanged.
- R8: Operation 7 returns 0x01 when bit n of the accumulator is 1, and 0x00 otherwise.
- R9: For operations 0 to 3, an operand of 0 returns the accumulator unchanged.
- R10: The result depends only on the present inputs and follows an input change within the same clock period, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Current accumulator value |
| op_i | input | 3 | Operation select (0 to 7, as in R1 to R8) |
| pos_i | input | 3 | Shift or rotate amount, or bit index |
| result_o | output | 8 | New accumulator value |

## Verification
The assertions are immediate checks evaluated inside combinational processes. They assume that all three inputs carry known two-level values that have settled before the result is compared. Every 3-bit operation code and every operand value is legal, so no input encoding needs to be excluded. The stimulus changes inputs only between clock edges and compares the result some time after each change. It covers the whole input space of 256 accumulator values, 8 operations and 8 operand values.

// File: rtl/bpi_pkg.sv
package bpi_pkg;

    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_LSL = 3'd1,
        OP_LSR = 3'd2,
        OP_ASR = 3'd3,
        OP_CLR = 3'd4,
        OP_SET = 3'd5,
        OP_TOG = 3'd6,
        OP_EXT = 3'd7
    } bpi_op_e;

endpackage

// File: rtl/bpi_shift.sv
module bpi_shift
    import bpi_pkg::*;
#(
    parameter int W     = 8,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     data_i,
    input  bpi_op_e          mode_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     data_o
);

    logic [W-1:0] stg [AMT_W+1];

    assign stg[0] = data_i;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [W-1:0] shf;

        always_comb begin
            unique case (mode_i)
                OP_ROL:  shf = {stg[k][W-1-D:0], stg[k][W-1:W-D]};
                OP_LSL:  shf = {stg[k][W-1-D:0], {D{1'b0}}};
                OP_LSR:  shf = {{D{1'b0}}, stg[k][W-1:D]};
                OP_ASR:  shf = {{D{stg[k][W-1]}}, stg[k][W-1:D]};
                default: shf = stg[k];
            endcase
        end

        assign stg[k+1] = amt_i[k] ? shf : stg[k];
    end

    assign data_o = stg[AMT_W];

endmodule

// File: rtl/bpi_bitop.sv
module bpi_bitop
    import bpi_pkg::*;
#(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     data_i,
    input  bpi_op_e          mode_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [W-1:0]     data_o
);

    logic [W-1:0] sel_mask;

    for (genvar i = 0; i < W; i++) begin : g_dec
        assign sel_mask[i] = (idx_i == IDX_W'(i));
    end

    always_comb begin
        unique case (mode_i)
            OP_CLR:  data_o = data_i & ~sel_mask;
            OP_SET:  data_o = data_i | sel_mask;
            OP_TOG:  data_o = data_i ^ sel_mask;
            OP_EXT:  data_o = {{(W-1){1'b0}}, |(data_i & sel_mask)};
            default: data_o = data_i;
        endcase
    end

endmodule

// File: rtl/bitpos_imm_unit.sv
module bitpos_imm_unit
    import bpi_pkg::*;
#(
    parameter  int WIDTH = 8,
    localparam int SEL_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] acc_i,
    input  logic [2:0]       op_i,
    input  logic [SEL_W-1:0] pos_i,
    output logic [WIDTH-1:0] result_o
);

    bpi_op_e          op_sel;
    logic [WIDTH-1:0] move_res;
    logic [WIDTH-1:0] bit_res;

    assign op_sel = bpi_op_e'(op_i);

    bpi_shift #(.W(WIDTH), .AMT_W(SEL_W)) u_shift (
        .data_i (acc_i),
        .mode_i (op_sel),
        .amt_i  (pos_i),
        .data_o (move_res)
    );

    bpi_bitop #(.W(WIDTH), .IDX_W(SEL_W)) u_bitop (
        .data_i (acc_i),
        .mode_i (op_sel),
        .idx_i  (pos_i),
        .data_o (bit_res)
    );

    always_comb begin
        unique case (op_sel)
            OP_ROL, OP_LSL, OP_LSR, OP_ASR: result_o = move_res;
            default:                        result_o = bit_res;
        endcase
    end

endmodule

// File: rtl/bpi_checker.sv
module bpi_checker
    import bpi_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input logic [W-1:0]     acc,
    input logic [2:0]       op,
    input logic [SEL_W-1:0] pos,
    input logic [W-1:0]     result
);

    logic [W-1:0] low_mask;
    logic [W-1:0] keep_mask;

    assign low_mask  = (W'(1) << pos) - W'(1);
    assign keep_mask = {W{1'b1}} >> pos;

    always_comb begin
        if (op == OP_ROL) begin
            assert_rol_keeps_ones_R1: assert ($countones(result) == $countones(acc))
                else $error("rotate changed population count");
        end
        if (op == OP_LSL) begin
            assert_lsl_low_zero_R2: assert ((result & low_mask) == '0)
                else $error("left shift did not zero-fill");
        end
        if (op == OP_LSR) begin
            assert_lsr_high_zero_R3: assert ((result & ~keep_mask) == '0)
                else $error("logical right shift did not zero-fill");
        end
        if (op == OP_ASR) begin
            assert_asr_sign_kept_R4: assert (result[W-1] == acc[W-1])
                else $error("arithmetic shift lost sign");
        end
        if (op == OP_CLR) begin
            assert_clr_bit_low_R5: assert (!result[pos] && ((result & ~acc) == '0))
                else $error("clear bit wrong");
        end
        if (op == OP_SET) begin
            assert_set_bit_high_R6: assert (result[pos] && ((acc & ~result) == '0))
                else $error("set bit wrong");
        end
        if (op == OP_TOG) begin
            assert_tog_one_bit_R7: assert (($countones(result ^ acc) == 1) && (result[pos] != acc[pos]))
                else $error("toggle bit wrong");
        end
        if (op == OP_EXT) begin
            assert_ext_flag_R8: assert ((result[W-1:1] == '0) && (result[0] == acc[pos]))
                else $error("extract wrong");
        end
        if (!op[2] && pos == '0) begin
            assert_zero_amount_identity_R9: assert (result == acc)
                else $error("zero amount altered value");
        end
    end

endmodule

bind bitpos_imm_unit bpi_checker #(.W(WIDTH), .SEL_W(SEL_W)) u_chk (
    .acc    (acc_i),
    .op     (op_i),
    .pos    (pos_i),
    .result (result_o)
);

// File: tb/sim_bitpos_imm_unit.sv
`timescale 1ns/1ps
module sim_bitpos_imm_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc;
    logic [2:0] op;
    logic [2:0] pos;
    logic [7:0] res;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    bitpos_imm_unit u0 (
        .acc_i    (acc),
        .op_i     (op),
        .pos_i    (pos),
        .result_o (res)
    );

    // {req[25:22], acc[21:14], op[13:11], n[10:8], expected[7:0]}
    localparam logic [25:0] VEC [17] = '{
        {4'd1, 8'h81, 3'd0, 3'd1, 8'h03},  // R1
        {4'd9, 8'h81, 3'd0, 3'd0, 8'h81},  // R9
        {4'd1, 8'h12, 3'd0, 3'd4, 8'h21},  // R1
        {4'd2, 8'h0F, 3'd1, 3'd3, 8'h78},  // R2
        {4'd2, 8'hFF, 3'd1, 3'd7, 8'h80},  // R2
        {4'd3, 8'hF0, 3'd2, 3'd4, 8'h0F},  // R3
        {4'd3, 8'h80, 3'd2, 3'd7, 8'h01},  // R3
        {4'd4, 8'h80, 3'd3, 3'd3, 8'hF0},  // R4
        {4'd4, 8'h40, 3'd3, 3'd2, 8'h10},  // R4
        {4'd5, 8'hFF, 3'd4, 3'd0, 8'hFE},  // R5
        {4'd5, 8'hFF, 3'd4, 3'd7, 8'h7F},  // R5
        {4'd6, 8'h00, 3'd5, 3'd7, 8'h80},  // R6
        {4'd6, 8'h55, 3'd5, 3'd0, 8'h55},  // R6
        {4'd7, 8'h55, 3'd6, 3'd1, 8'h57},  // R7
        {4'd8, 8'h55, 3'd7, 3'd2, 8'h01},  // R8
        {4'd8, 8'h55, 3'd7, 3'd3, 8'h00},  // R8
        {4'd9, 8'hC3, 3'd3, 3'd0, 8'hC3}   // R9
    };

    function automatic logic [7:0] model(input logic [7:0] a, input logic [2:0] o, input logic [2:0] n);
        logic [7:0] r;
        r = a;
        case (o)
            3'd0: for (int i = 0; i < 8; i++) r[(i + int'(n)) % 8] = a[i];
            3'd1: r = a << n;
            3'd2: r = a >> n;
            3'd3: for (int i = 0; i < 8; i++) r[i] = (i + int'(n) > 7) ? a[7] : a[i + int'(n)];
            3'd4: r[n] = 1'b0;
            3'd5: r[n] = 1'b1;
            3'd6: r[n] = ~a[n];
            default: r = {7'd0, a[n]};
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] o, input logic [2:0] n);
        if (o < 3'd4 && n == 3'd0) return "R9";
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: acc=%h op=%0d n=%0d actual=%h expected=%h", req, acc, op, pos, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [2:0] o, input logic [2:0] n);
        @(posedge clk);
        #2;
        acc = a;
        op  = o;
        pos = n;
        #3;
    endtask

    initial begin
        acc = 8'h00;
        op  = 3'd0;
        pos = 3'd0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset-state", res, 8'h00);
        rst = 1'b0;

        foreach (VEC[i]) begin
            apply(VEC[i][21:14], VEC[i][13:11], VEC[i][10:8]);
            check($sformatf("R%0d table", VEC[i][25:22]), res, VEC[i][7:0]);
        end

        // R10: two input changes inside one clock period, no edge between
        @(posedge clk);
        #1;
        acc = 8'hA5; op = 3'd6; pos = 3'd0;
        #1;
        check("R10 same-period", res, 8'hA4);
        acc = 8'hA5; op = 3'd2; pos = 3'd1;
        #1;
        check("R10 same-period", res, 8'h52);

        for (int a = 0; a < 256; a++) begin
            for (int o = 0; o < 8; o++) begin
                for (int n = 0; n < 8; n++) begin
                    apply(8'(a), 3'(o), 3'(n));
                    check(tag_of(3'(o), 3'(n)), res, model(8'(a), 3'(o), 3'(n)));
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule